// File: doc/BRIEF.md
# Two-bank overlapped burst sequencer

This block runs one four-long-word (16-byte) burst read or write against a pair of DRAM banks. A request carries a long-word address whose two low bits are ignored (the burst is aligned, words 0..3 in ascending order), a direction and a mode flag from the bank decoder. In linear mode the whole burst comes from one bank: one full access followed by three page-mode accesses under a single row strobe. In interleaved mode the even words (0 and 2) live in bank 0 and the odd words (1 and 3) in bank 1; the bank-1 access starts a fixed offset after the bank-0 access, so the two row/column cycles overlap and part of the latency of words 1 and 3 is hidden.

Whatever order the banks finish in, the processor side sees exactly one `word_rdy` pulse per long word, in word order 0, 1, 2, 3, with `word_idx` naming the word. The request side is a valid/ready handshake: a burst is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low until the burst has ended and both banks have rested with row strobes high for the precharge interval. A requester may hold `req_valid` high at any time; back-pressure is expressed only through `req_ready`. `word_rdy` has no back-pressure, since DRAM timing cannot stall. Latencies are parameters in clock cycles: `T_FULL` (full access), `T_PAGE` (page access), `T_OFF` (bank-1 start offset) and `T_PRE` (precharge).

Top module: `ilv_burst_seq`

## Requirements
- R1: `req_ready` is high only in the idle state; a burst is taken on an edge with `req_valid` and `req_ready` high, `req_ready` is low from the next cycle, and requests presented while it is low have no effect on any output.
- R2: Linear mode (`req_ilv`=0): the bank is `req_addr[AW-1]` (0 = bank 0); its active-low row strobe is low for cycles 0 to `T_FULL`+3*`T_PAGE`-1 after the accepting edge (cycle 0 is the first cycle after it); the other bank's row strobe stays high.
- R3: Interleaved mode (`req_ilv`=1): bank 0's row strobe is low for cycles 0 to `T_FULL`+`T_PAGE`-1 and bank 1's for cycles `T_OFF` to `T_OFF`+`T_FULL`+`T_PAGE`-1.
- R4: Within a bank, access 0 lasts `T_FULL` cycles and each later access `T_PAGE` cycles; the active-low column strobe is low in the last `T_PAGE`-1 cycles of every access and high otherwise.
- R5: The bank address bus carries the row for the first `T_FULL`-`T_PAGE` cycles of access 0 and the column otherwise, and is 0 while the bank is inactive. The in-bank long-word address of access k is `{addr[AW-1:2], k[0]}` when interleaved and `addr[AW-2:0]` with its low two bits replaced by k when linear; the column is its low `COL_W` bits, the row the rest.
- R6: Word w completes at the end of its access (linear: cycle `T_FULL`-1+w*`T_PAGE`; interleaved: bank w%2, access w/2); `word_rdy` pulses with `word_idx`=w in cycle max(completion+1, previous pulse+1), once per word, in order 0..3.
- R7: Mode, address and direction are captured at acceptance; changes to those inputs during a burst have no effect on it.
- R8: `req_ready` rises exactly `T_PRE`+1 cycles after the last `word_rdy` pulse, and both row strobes are high in between.
- R9: A bank's active-low write enable is low exactly while its row strobe is low in a write burst, and stays high in a read burst.
- R10: Under reset all strobes and write enables are high, `word_rdy` is low, and `req_ready` is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Sequencer can take a burst |
| req_addr | input | AW | Long-word address; bits [1:0] ignored, bit AW-1 selects the bank in linear mode |
| req_ilv | input | 1 | 1 = interleaved pair, 0 = linear |
| req_write | input | 1 | 1 = write burst |
| word_rdy | output | 1 | One pulse per long word |
| word_idx | output | 2 | Word number of the current pulse |
| dram_ras_n | output | 2 | Row strobes, bit b for bank b, active low |
| dram_cas_n | output | 2 | Column strobes, active low |
| dram_we_n | output | 2 | Write enables, active low |
| dram_ma0 | output | MA_W | Bank 0 multiplexed address |
| dram_ma1 | output | MA_W | Bank 1 multiplexed address |

## Verification
A bank engine with a wrong cycle or access count shows up as a column strobe or address edge that is off by a cycle within the first `T_FULL` cycles of the burst, and as a row strobe that closes early or late. A corrupted word pointer or pending set in the ordering unit shows as a missing, repeated or out-of-order `word_idx`, and then as `req_ready` never returning, so the fault is visible within one burst. Mode or address state taken after acceptance instead of at it shows as the wrong bank strobing when inputs are disturbed mid-burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_PRE  = 2'd2
  } seq_state_e;

  localparam int unsigned BURST_WORDS = 4;
  localparam int unsigned NUM_BANKS   = 2;
endpackage

// File: rtl/burst_bank_engine.sv
module burst_bank_engine #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int MA_W   = 4,
  parameter int T_FULL = 4,
  parameter int T_PAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       last_acc,
  input  logic [ROW_W-1:0] row_in,
  input  logic [COL_W-1:0] col_in,
  input  logic             wr_in,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [MA_W-1:0]  ma,
  output logic             busy,
  output logic             acc_done,
  output logic [1:0]       acc_k
);
  localparam int CW = $clog2(T_FULL + 1);
  localparam logic [CW-1:0] LEN_FULL = CW'(T_FULL);
  localparam logic [CW-1:0] LEN_PAGE = CW'(T_PAGE);
  localparam logic [CW-1:0] CAS_ON   = CW'(T_PAGE - 1);
  localparam logic [CW-1:0] ROW_CYC  = CW'(T_FULL - T_PAGE);

  logic             act_q;
  logic [CW-1:0]    c_q;
  logic [1:0]       k_q;
  logic [1:0]       last_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [CW-1:0]    len;
  logic             end_acc;
  logic             row_phase;

  assign len       = (k_q == 2'd0) ? LEN_FULL : LEN_PAGE;
  assign end_acc   = act_q && (c_q == len - CW'(1));
  assign row_phase = (k_q == 2'd0) && (c_q < ROW_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      c_q    <= '0;
      k_q    <= '0;
      last_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
    end else if (start) begin
      act_q  <= 1'b1;
      c_q    <= '0;
      k_q    <= '0;
      last_q <= last_acc;
      row_q  <= row_in;
      col_q  <= col_in;
      wr_q   <= wr_in;
    end else if (act_q) begin
      if (end_acc) begin
        c_q <= '0;
        if (k_q == last_q) act_q <= 1'b0;
        else k_q <= k_q + 2'd1;
      end else begin
        c_q <= c_q + CW'(1);
      end
    end
  end

  always_comb begin
    ras_n = ~act_q;
    cas_n = ~(act_q && (c_q >= len - CAS_ON));
    we_n  = ~(act_q && wr_q);
    if (!act_q)         ma = '0;
    else if (row_phase) ma = MA_W'(row_q);
    else                ma = MA_W'(col_q + COL_W'(k_q));
  end

  assign busy     = act_q;
  assign acc_done = end_acc;
  assign acc_k    = k_q;
endmodule

// File: rtl/burst_word_order.sv
module burst_word_order (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [3:0] done_set,
  output logic       word_rdy,
  output logic [1:0] word_idx,
  output logic       all_out
);
  logic [3:0] pend_q;
  logic [2:0] nxt_q;
  logic [3:0] avail;
  logic       fire;

  assign avail = pend_q | done_set;
  assign fire  = !nxt_q[2] && avail[nxt_q[1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      nxt_q    <= '0;
      word_rdy <= 1'b0;
      word_idx <= '0;
    end else if (clear) begin
      pend_q   <= '0;
      nxt_q    <= '0;
      word_rdy <= 1'b0;
      word_idx <= '0;
    end else begin
      pend_q   <= avail;
      word_rdy <= fire;
      if (fire) begin
        word_idx <= nxt_q[1:0];
        nxt_q    <= nxt_q + 3'd1;
      end
    end
  end

  assign all_out = nxt_q[2];
endmodule

// File: rtl/ilv_burst_seq.sv
module ilv_burst_seq
  import burst_seq_pkg::*;
#(
  parameter int AW     = 9,
  parameter int COL_W  = 4,
  parameter int T_FULL = 4,
  parameter int T_PAGE = 2,
  parameter int T_OFF  = 2,
  parameter int T_PRE  = 1,
  localparam int BA_W  = AW - 1,
  localparam int ROW_W = BA_W - COL_W,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_ilv,
  input  logic            req_write,
  output logic            word_rdy,
  output logic [1:0]      word_idx,
  output logic [1:0]      dram_ras_n,
  output logic [1:0]      dram_cas_n,
  output logic [1:0]      dram_we_n,
  output logic [MA_W-1:0] dram_ma0,
  output logic [MA_W-1:0] dram_ma1
);
  localparam int CYW = $clog2(T_OFF + 1);
  localparam int PW  = (T_PRE > 1) ? $clog2(T_PRE) : 1;

  seq_state_e      st_q;
  logic [CYW-1:0]  cyc_q;
  logic [PW-1:0]   pc_q;
  logic            ilv_q;
  logic            wr_q;
  logic [BA_W-1:0] base_q;
  logic [BA_W-1:0] base_d;
  logic [BA_W-1:0] base_sel;
  logic            accept;
  logic            odd_go;
  logic            ilv_sel;
  logic            wr_sel;
  logic [1:0]      last_sel;
  logic [1:0]      eng_start;
  logic [1:0]      busy;
  logic [1:0]      acc_done;
  logic [1:0]      acc_k [NUM_BANKS];
  logic [MA_W-1:0] ma_w  [NUM_BANKS];
  logic [3:0]      done_set;
  logic            all_out;

  assign req_ready = (st_q == SQ_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (req_ilv) base_d = {req_addr[AW-1:2], 1'b0};
    else         base_d = {req_addr[AW-2:2], 2'b00};
  end

  assign odd_go   = (st_q == SQ_RUN) && ilv_q && (cyc_q == CYW'(T_OFF - 1));
  assign ilv_sel  = accept ? req_ilv : ilv_q;
  assign wr_sel   = accept ? req_write : wr_q;
  assign base_sel = accept ? base_d : base_q;
  assign last_sel = ilv_sel ? 2'd1 : 2'd3;

  assign eng_start[0] = accept && (req_ilv || !req_addr[AW-1]);
  assign eng_start[1] = (accept && !req_ilv && req_addr[AW-1]) || odd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cyc_q  <= '0;
      pc_q   <= '0;
      ilv_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (accept) begin
          st_q   <= SQ_RUN;
          cyc_q  <= '0;
          ilv_q  <= req_ilv;
          wr_q   <= req_write;
          base_q <= base_d;
        end
        SQ_RUN: begin
          if (cyc_q != CYW'(T_OFF)) cyc_q <= cyc_q + CYW'(1);
          if (all_out && (busy == 2'b00)) begin
            st_q <= SQ_PRE;
            pc_q <= '0;
          end
        end
        SQ_PRE: begin
          if (pc_q == PW'(T_PRE - 1)) st_q <= SQ_IDLE;
          else pc_q <= pc_q + PW'(1);
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    burst_bank_engine #(
      .ROW_W (ROW_W),
      .COL_W (COL_W),
      .MA_W  (MA_W),
      .T_FULL(T_FULL),
      .T_PAGE(T_PAGE)
    ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (eng_start[b]),
      .last_acc(last_sel),
      .row_in  (base_sel[BA_W-1:COL_W]),
      .col_in  (base_sel[COL_W-1:0]),
      .wr_in   (wr_sel),
      .ras_n   (dram_ras_n[b]),
      .cas_n   (dram_cas_n[b]),
      .we_n    (dram_we_n[b]),
      .ma      (ma_w[b]),
      .busy    (busy[b]),
      .acc_done(acc_done[b]),
      .acc_k   (acc_k[b])
    );
  end

  assign dram_ma0 = ma_w[0];
  assign dram_ma1 = ma_w[1];

  always_comb begin
    done_set = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (acc_done[b]) begin
        if (ilv_q) done_set[{acc_k[b][0], 1'(b)}] = 1'b1;
        else       done_set[acc_k[b]]             = 1'b1;
      end
    end
  end

  burst_word_order u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .done_set(done_set),
    .word_rdy(word_rdy),
    .word_idx(word_idx),
    .all_out (all_out)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       word_rdy,
  input logic [1:0] word_idx,
  input logic [1:0] dram_ras_n,
  input logic [1:0] dram_cas_n,
  input logic [1:0] dram_we_n
);
  logic [2:0] exp_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      exp_idx <= '0;
    else if (req_valid && req_ready) exp_idx <= '0;
    else if (word_rdy)               exp_idx <= exp_idx + 3'd1;
  end

  a_r1_no_ready_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    word_rdy |-> !req_ready);

  a_r8_idle_rows_closed: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n == 2'b11));

  a_r8_precharge_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(dram_ras_n) == 2'b11));

  a_r4_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dram_cas_n) & dram_ras_n) == 2'b00);

  a_r9_we_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dram_we_n) & dram_ras_n) == 2'b00);

  a_r6_word_order: assert property (@(posedge clk) disable iff (!rst_n)
    word_rdy |-> (!exp_idx[2] && (word_idx == exp_idx[1:0])));
endmodule

bind ilv_burst_seq burst_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .word_rdy  (word_rdy),
  .word_idx  (word_idx),
  .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n),
  .dram_we_n (dram_we_n)
);

// File: tb/sim_ilv_burst_seq.sv
module sim_ilv_burst_seq;
  localparam int AW = 9, COL_W = 4, TF = 4, TP = 2, TO = 2, TPR = 1;
  localparam int MA_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ilv = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, word_rdy;
  logic [1:0] word_idx, dram_ras_n, dram_cas_n, dram_we_n;
  logic [MA_W-1:0] dram_ma0, dram_ma1;

  always #10 clk = ~clk;

  ilv_burst_seq #(.AW(AW), .COL_W(COL_W), .T_FULL(TF), .T_PAGE(TP),
                  .T_OFF(TO), .T_PRE(TPR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ilv(req_ilv), .req_write(req_write),
    .word_rdy(word_rdy), .word_idx(word_idx), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_ma0(dram_ma0), .dram_ma1(dram_ma1));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected pins of bank b in cycle e of a burst
  task automatic bank_exp(input int b, input int e, input int addr, input int ilv,
                          input int wr, output int ras, output int cas,
                          output int we, output int ma);
    int used, sb, nacc, t, span, k, c, len, inb;
    used = ilv ? 1 : (b == ((addr >> (AW-1)) & 1));
    sb   = ilv ? b * TO : 0;
    nacc = ilv ? 2 : 4;
    t    = e - sb;
    span = TF + (nacc - 1) * TP;
    ras = 1; cas = 1; we = 1; ma = 0;
    if (used != 0 && t >= 0 && t < span) begin
      if (t < TF) begin k = 0; c = t; len = TF; end
      else begin k = 1 + (t - TF) / TP; c = (t - TF) % TP; len = TP; end
      ras = 0;
      cas = (c >= len - (TP - 1)) ? 0 : 1;
      we  = wr ? 0 : 1;
      if (ilv) inb = (addr >> 2) * 2 + k;
      else     inb = (addr & ((1 << (AW-1)) - 1)) + k;
      ma = (k == 0 && c < TF - TP) ? (inb >> COL_W) : (inb % (1 << COL_W));
    end
  endtask

  // entered at a negedge where req_ready is expected high
  task automatic burst(input int addr, input int ilv, input int wr, input bit noise);
    int d[4], r[4], last, ras, cas, we, ma, rdy_e, idx_e;
    string pre;
    pre = noise ? "R1/R7 " : "";
    for (int w = 0; w < 4; w++) begin
      if (ilv) d[w] = (w % 2) * TO + TF - 1 + (w / 2) * TP;
      else     d[w] = TF - 1 + w * TP;
      r[w] = d[w] + 1;
      if (w > 0 && r[w] <= r[w-1]) r[w] = r[w-1] + 1;
    end
    last = r[3] + TPR + 1;
    chk({pre, "R1 ready before accept"}, int'(req_ready), 1);
    req_valid = 1'b1; req_addr = AW'(addr); req_ilv = ilv[0]; req_write = wr[0];
    @(posedge clk); @(negedge clk);
    for (int e = 0; e <= last; e++) begin
      for (int b = 0; b < 2; b++) begin
        bank_exp(b, e, addr, ilv, wr, ras, cas, we, ma);
        chk({pre, ilv ? "R3 ras" : "R2 ras"}, int'(dram_ras_n[b]), ras);
        chk({pre, "R4 cas"}, int'(dram_cas_n[b]), cas);
        chk({pre, "R9 we"}, int'(dram_we_n[b]), we);
        chk({pre, "R5 ma"}, b ? int'(dram_ma1) : int'(dram_ma0), ma);
      end
      rdy_e = 0; idx_e = 0;
      for (int w = 0; w < 4; w++) if (r[w] == e) begin rdy_e = 1; idx_e = w; end
      chk({pre, "R6 word_rdy"}, int'(word_rdy), rdy_e);
      if (rdy_e != 0) chk({pre, "R6 word_idx"}, int'(word_idx), idx_e);
      chk({pre, "R8 req_ready"}, int'(req_ready), (e >= last) ? 1 : 0);
      if (noise && e < last) begin
        req_addr  = AW'((addr ^ (e * 37 + 5)));
        req_ilv   = ~req_ilv;
        req_write = ~req_write;
      end else begin
        req_valid = 1'b0;
      end
      if (e < last) begin @(posedge clk); @(negedge clk); end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ras in reset", int'(dram_ras_n), 3);
    chk("R10 cas in reset", int'(dram_cas_n), 3);
    chk("R10 we in reset", int'(dram_we_n), 3);
    chk("R10 word_rdy in reset", int'(word_rdy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 req_ready after reset", int'(req_ready), 1);
    // every aligned burst address, both modes, direction varied
    for (int a = 0; a < (1 << (AW-2)); a++)
      for (int m = 0; m < 2; m++)
        burst(a << 2, m, (a ^ m) & 1, 1'b0);
    // disturbed inputs during busy bursts
    for (int a = 0; a < 8; a++)
      burst(((a * 53) & ((1 << (AW-2)) - 1)) << 2, a & 1, (a >> 1) & 1, 1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule